// File: doc/BRIEF.md
# Eight-Bit Timer/Counter with Switchable Prescaler

This block is an 8-bit up-counter that a small processor core reads and loads over its data bus. Each clock of the block is one instruction cycle. The counter can be driven in one of two ways. In internal mode it takes one step per instruction cycle. In external mode it takes one step per chosen edge of an input pin, and that pin first passes through a synchronizer.

One 8-bit prescaler serves one of two clients. It can sit in front of the counter. It can instead divide a watchdog tick stream, and in that case the counter runs undivided. A bus write to the count suppresses counting for the next two instruction cycles. Software allows for this by loading an adjusted value. When the count wraps, the block raises a single-cycle overflow pulse.

A six-bit control register selects the mode. Its bus layout is: bit 5 selects the source, bit 4 selects the edge, bit 3 assigns the prescaler, and bits 2..0 hold the rate.

Top module: `tick_timer8`

## Requirements
- R1: A synchronous reset clears the count to 0 and holds `ovf_pulse` low. It loads the control register with 6'b111111: external source, falling edge, prescaler on the watchdog, rate 7.
- R2: When `wr_en` is high at a clock edge, that edge loads `wr_data` into the count, and `rd_data` always shows the count. When `cfg_we` is high at a clock edge, that edge loads `cfg_data` into the control register, and `cfg_q` shows the register. The control fields are: [5] source (0 internal, 1 external), [4] edge (0 rising, 1 falling), [3] prescaler assignment (0 counter, 1 watchdog), [2:0] rate.
- R3: With the internal source and the prescaler on the watchdog, the count rises by one at every clock edge, wrapping from 0xFF to 0x00.
- R4: After the edge that loads the count, the next two edges leave the count unchanged. The third edge is the first one that can advance it.
- R5: With the external source, the selected pin edge advances the count at the third clock edge after the pin changes. The opposite pin edge leaves the count unchanged.
- R6: With the prescaler on the watchdog, the counter advances once per source event at any rate setting. With the prescaler on the counter, `wdt_tick_out` equals `wdt_tick_in` in the same cycle.
- R7: With the prescaler on the counter, the count advances once per 2^(rate+1) source events.
- R8: A count load while the prescaler is on the counter clears the prescaler, so the next step comes 2^(rate+1) events later.
- R9: The edge that wraps the count from 0xFF to 0x00 makes `ovf_pulse` high for exactly the following cycle. A write never raises it.
- R10: With the prescaler on the watchdog, `wdt_tick_out` is high, combinationally, during every 2^(rate+1)-th high cycle of `wdt_tick_in`, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Load the count from `wr_data` |
| wr_data | input | 8 | Bus data for the count |
| rd_data | output | 8 | Current count |
| cfg_we | input | 1 | Load the control register |
| cfg_data | input | 6 | Control value: [5] source, [4] edge, [3] assignment, [2:0] rate |
| cfg_q | output | 6 | Current control register |
| ext_pin | input | 1 | External count input, asynchronous |
| wdt_tick_in | input | 1 | Raw watchdog tick, one cycle per tick |
| wdt_tick_out | output | 1 | Watchdog tick after the prescaler or pass-through |
| ovf_pulse | output | 1 | One-cycle pulse on count wrap |

## Verification
Some behaviour is checked by assertions on every cycle:
- the count holds through the two cycles after a load;
- the overflow pulse is one cycle wide and coincides with a zero count;
- every external event matches the pin level two edges earlier;
- the prescaler's low bits return to zero after each output;
- a divided watchdog tick never appears without an input tick.

Other behaviour can only be shown by the directed scenarios:
- the exact step cycle in each mode;
- the division ratios;
- the prescaler clear on a load, which shifts the next step by one cycle;
- that the unselected pin edge is ignored.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CNT_W   = 8;
    localparam int PS_W    = 8;
    localparam int RATE_W  = 3;
    localparam int SYNC_N  = 2;
    localparam int HOLD_N  = 2;

    typedef struct packed {
        logic              src_ext;
        logic              edge_fall;
        logic              ps_wdt;
        logic [RATE_W-1:0] rate;
    } tmr_cfg_t;

    localparam int CFG_W = $bits(tmr_cfg_t);

    localparam tmr_cfg_t CFG_RESET = '{
        src_ext:   1'b1,
        edge_fall: 1'b1,
        ps_wdt:    1'b1,
        rate:      {RATE_W{1'b1}}
    };

    // Low (rate+1) bits set: the prescaler fires when these are all ones.
    function automatic logic [PS_W-1:0] rate_mask(input logic [RATE_W-1:0] r);
        logic [PS_W-1:0] m;
        for (int i = 0; i < PS_W; i++) begin
            m[i] = (i <= int'(r));
        end
        return m;
    endfunction

endpackage

// File: rtl/tmr_insync.sv
module tmr_insync #(
    parameter int STAGES = tmr_pkg::SYNC_N
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic edge_fall,
    output logic ev
);

    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], pin};
            last  <= chain[STAGES-1];
        end
    end

    logic rise, fall;
    assign rise = chain[STAGES-1] & ~last;
    assign fall = ~chain[STAGES-1] & last;
    assign ev   = edge_fall ? fall : rise;

    // R5: an event reflects the pin level seen STAGES edges earlier
    p_sync_r5: assert property (@(posedge clk) disable iff (rst)
        ev |-> ($past(pin, STAGES) == !edge_fall));

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
#(
    parameter int W = PS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_in,
    input  logic              clr,
    input  logic [RATE_W-1:0] rate,
    output logic              ev_out
);

    logic [W-1:0] pcnt;
    logic [W-1:0] mask;

    assign mask   = rate_mask(rate);
    assign ev_out = ev_in && ((pcnt & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pcnt <= '0;
        end else if (ev_in) begin
            pcnt <= pcnt + 1'b1;
        end
    end

    // R7: after a divided output the selected low bits restart at zero
    p_div_r7: assert property (@(posedge clk) disable iff (rst)
        (ev_out && !clr) |=> ((pcnt & $past(mask)) == '0));

endmodule

// File: rtl/tmr_count.sv
module tmr_count
    import tmr_pkg::*;
#(
    parameter int W    = CNT_W,
    parameter int HOLD = HOLD_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         ovf
);

    localparam int HW = $clog2(HOLD + 1);

    logic [HW-1:0] hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            hold <= '0;
            ovf  <= 1'b0;
        end else begin
            ovf <= 1'b0;
            if (wr_en) begin
                cnt  <= wr_data;
                hold <= HW'(HOLD);
            end else if (hold != '0) begin
                hold <= hold - 1'b1;
            end else if (inc) begin
                cnt <= cnt + 1'b1;
                ovf <= (cnt == '1);
            end
        end
    end

    // R4: count holds in the first cycle after a load
    p_hold1_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && !$past(rst) && !wr_en) |=> $stable(cnt));

    // R4: count holds in the second cycle after a load
    p_hold2_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en, 2) && !$past(rst, 2) && !$past(rst) && !$past(wr_en) && !wr_en)
        |=> $stable(cnt));

    // R9: overflow pulse coincides with a zero count
    p_ovf_zero_r9: assert property (@(posedge clk) disable iff (rst)
        ovf |-> (cnt == '0));

    // R9: overflow pulse lasts one cycle
    p_ovf_once_r9: assert property (@(posedge clk) disable iff (rst)
        ovf |=> !ovf);

endmodule

// File: rtl/tick_timer8.sv
module tick_timer8
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] rd_data,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_data,
    output logic [CFG_W-1:0] cfg_q,
    input  logic             ext_pin,
    input  logic             wdt_tick_in,
    output logic             wdt_tick_out,
    output logic             ovf_pulse
);

    tmr_cfg_t cfg;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
        end else if (cfg_we) begin
            cfg <= tmr_cfg_t'(cfg_data);
        end
    end

    assign cfg_q = cfg;

    logic ext_ev, src_ev, ps_in, ps_out, ps_clr, cnt_inc;

    tmr_insync #(.STAGES(SYNC_N)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .pin       (ext_pin),
        .edge_fall (cfg.edge_fall),
        .ev        (ext_ev)
    );

    assign src_ev  = cfg.src_ext ? ext_ev : 1'b1;
    assign ps_in   = cfg.ps_wdt  ? wdt_tick_in : src_ev;
    assign ps_clr  = wr_en && !cfg.ps_wdt;

    tmr_prescale #(.W(PS_W)) u_ps (
        .clk    (clk),
        .rst    (rst),
        .ev_in  (ps_in),
        .clr    (ps_clr),
        .rate   (cfg.rate),
        .ev_out (ps_out)
    );

    assign cnt_inc      = cfg.ps_wdt ? src_ev : ps_out;
    assign wdt_tick_out = cfg.ps_wdt ? ps_out : wdt_tick_in;

    tmr_count #(.W(CNT_W), .HOLD(HOLD_N)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .inc     (cnt_inc),
        .cnt     (rd_data),
        .ovf     (ovf_pulse)
    );

    // R10: a divided watchdog tick only appears alongside a raw tick
    p_wdt_div_r10: assert property (@(posedge clk) disable iff (rst)
        (cfg.ps_wdt && wdt_tick_out) |-> wdt_tick_in);

endmodule

// File: tb/tb_tick_timer8.sv
module tb_tick_timer8;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       cfg_we;
    logic [5:0] cfg_data;
    logic [5:0] cfg_q;
    logic       ext_pin;
    logic       wdt_tick_in;
    logic       wdt_tick_out;
    logic       ovf_pulse;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #5 clk = ~clk;

    tick_timer8 dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .cfg_we(cfg_we), .cfg_data(cfg_data), .cfg_q(cfg_q), .ext_pin(ext_pin),
        .wdt_tick_in(wdt_tick_in), .wdt_tick_out(wdt_tick_out), .ovf_pulse(ovf_pulse)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_cfg(input logic [5:0] v);
        cfg_we = 1'b1; cfg_data = v; tick(); cfg_we = 1'b0;
    endtask

    task automatic load(input logic [7:0] v);
        wr_en = 1'b1; wr_data = v; tick(); wr_en = 1'b0;
    endtask

    task automatic t_reset();
        chk(rd_data == 8'h00, "R1 count", rd_data, 0);
        chk(cfg_q == 6'h3F, "R1 cfg", cfg_q, 6'h3F);
        chk(ovf_pulse == 1'b0, "R1 ovf", ovf_pulse, 0);
    endtask

    task automatic t_timer();
        set_cfg(6'b001000);
        chk(cfg_q == 6'b001000, "R2 cfg load", cfg_q, 6'b001000);
        load(8'd10);
        chk(rd_data == 8'd10, "R2 count load", rd_data, 10);
        tick(); chk(rd_data == 8'd10, "R4 hold1", rd_data, 10);
        tick(); chk(rd_data == 8'd10, "R4 hold2", rd_data, 10);
        tick(); chk(rd_data == 8'd11, "R4 first step", rd_data, 11);
        tick(); chk(rd_data == 8'd12, "R3 step", rd_data, 12);
    endtask

    task automatic t_ovf();
        load(8'hFD);
        chk(ovf_pulse == 1'b0, "R9 no ovf on write", ovf_pulse, 0);
        tick(); tick(); tick();
        tick(); chk(rd_data == 8'hFF && !ovf_pulse, "R9 before wrap", rd_data, 8'hFF);
        tick(); chk(rd_data == 8'h00, "R3 wrap", rd_data, 0);
        chk(ovf_pulse == 1'b1, "R9 pulse", ovf_pulse, 1);
        tick(); chk(ovf_pulse == 1'b0, "R9 one cycle", ovf_pulse, 0);
    endtask

    task automatic t_prescale();
        set_cfg(6'b000001);
        load(8'd0);
        tick(); tick(); tick();
        chk(rd_data == 8'd0, "R7 not yet", rd_data, 0);
        tick(); chk(rd_data == 8'd1, "R7 first div4", rd_data, 1);
        tick(); tick(); tick();
        chk(rd_data == 8'd1, "R7 hold", rd_data, 1);
        tick(); chk(rd_data == 8'd2, "R7 second div4", rd_data, 2);
        tick(); tick();
        load(8'd50);
        tick(); tick(); tick();
        chk(rd_data == 8'd50, "R8 before", rd_data, 50);
        tick(); chk(rd_data == 8'd51, "R8 cleared prescaler", rd_data, 51);
    endtask

    task automatic t_ext();
        set_cfg(6'b101000);
        load(8'd0);
        tick(); tick(); tick();
        ext_pin = 1'b1;
        tick(); tick();
        chk(rd_data == 8'd0, "R5 sync delay", rd_data, 0);
        tick(); chk(rd_data == 8'd1, "R5 rising", rd_data, 1);
        ext_pin = 1'b0;
        tick(); tick(); tick(); tick();
        chk(rd_data == 8'd1, "R5 falling ignored", rd_data, 1);
        set_cfg(6'b111000);
        ext_pin = 1'b1;
        tick(); tick(); tick(); tick();
        chk(rd_data == 8'd1, "R5 rising ignored", rd_data, 1);
        ext_pin = 1'b0;
        tick(); tick();
        chk(rd_data == 8'd1, "R5 fall delay", rd_data, 1);
        tick(); chk(rd_data == 8'd2, "R5 falling", rd_data, 2);
    endtask

    task automatic t_wdt();
        logic [7:0] c0;
        set_cfg(6'b100001);
        load(8'd0);
        set_cfg(6'b001001);
        for (int i = 0; i < 4; i++) begin
            wdt_tick_in = 1'b1;
            #1;
            chk(wdt_tick_out == (i == 3), "R10 divided tick", wdt_tick_out, (i == 3));
            tick();
            wdt_tick_in = 1'b0;
            #1;
            chk(wdt_tick_out == 1'b0, "R10 idle", wdt_tick_out, 0);
            tick();
        end
        c0 = rd_data;
        tick(); tick(); tick(); tick();
        chk(rd_data == c0 + 8'd4, "R6 timer 1:1", rd_data, c0 + 8'd4);
        set_cfg(6'b100001);
        wdt_tick_in = 1'b1;
        #1;
        chk(wdt_tick_out == 1'b1, "R6 pass-through high", wdt_tick_out, 1);
        tick();
        wdt_tick_in = 1'b0;
        #1;
        chk(wdt_tick_out == 1'b0, "R6 pass-through low", wdt_tick_out, 0);
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_data = '0; cfg_we = 1'b0; cfg_data = '0;
        ext_pin = 1'b0; wdt_tick_in = 1'b0;
        tick(); tick(); tick();
        t_reset();
        rst = 1'b0;
        tick();
        t_timer();
        t_ovf();
        t_prescale();
        t_ext();
        t_wdt();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule